// File: doc/BRIEF.md
# Owed-Refresh Watermark Tracker

This block keeps count of how many DRAM refresh operations are currently owed and tells a memory scheduler how urgently they are needed. A programmable interval timer runs on the memory clock. Each time it expires, one more refresh is owed. Each refresh the scheduler grants pays one back. The owed count is compared with a low watermark to raise a low-priority request. It is compared with a high watermark to raise an urgent request. The urgent request has hysteresis: once raised, it stays up until the count has drained below a separate release level.

The block counts only while both the refresh enable and the DRAM-initialization-complete qualifier are high. The interval length is normally programmed so that one interval lasts 7.8 us at the memory clock rate. For example, 0x0C30 suits a 400 MHz clock and 0x0820 suits 266 MHz. The three thresholds are 4-bit values whose useful range is 0 to 8. The release level should be programmed below the high watermark.

Top module: `refresh_owed_tracker`

## Requirements
- R1: While `ref_en` is 0, the owed count is forced to 0 on the next clock, both request flags are 0, and the interval timer is held at its start.
- R2: While `init_done` is 0, the block behaves as in R1: no interval counting, no count change and no requests.
- R3: While active (`ref_en` and `init_done` both 1), the owed count rises by one every `interval_ld` clocks, with a value of 0 treated as 1. The first rise comes `interval_ld` clocks after the block becomes active.
- R4: `req_lo` is 1 exactly when the block is active and the owed count is strictly greater than `lo_mark`. It clears as soon as the count is no longer above it.
- R5: `req_hi` becomes 1 on the same clock edge at which the owed count becomes strictly greater than `hi_mark`, and not before.
- R6: Once set, `req_hi` stays 1 while the count is at or above `hyst_lvl`. It clears on the edge at which the count falls below `hyst_lvl`.
- R7: A `ref_grant` pulse while active lowers the owed count by one. A grant in the same cycle as an interval expiry leaves the count unchanged.
- R8: The owed count never goes below 0. A grant at count 0 has no effect.
- R9: The owed count saturates at 15 and does not wrap.
- R10: During and just after reset, the owed count is 0 and both request flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Refresh enable |
| init_done | input | 1 | DRAM initialization complete qualifier |
| interval_ld | input | 14 | Interval length in clocks |
| lo_mark | input | 4 | Low watermark |
| hi_mark | input | 4 | High watermark |
| hyst_lvl | input | 4 | Release level for the urgent flag |
| ref_grant | input | 1 | One-cycle strobe: scheduler issued a refresh |
| req_lo | output | 1 | Low-priority refresh request |
| req_hi | output | 1 | Urgent refresh request |
| owed_cnt | output | 4 | Current owed-refresh count |

## Verification
The bound checker watches every cycle for four things:
- Deactivation clears the count and the urgent flag.
- A lone grant lowers the count by one and a lone expiry raises it by one.
- The count never wraps from 15 to 0.
- Every rise or fall of the urgent flag agrees with the high watermark or the release level.

The directed scenarios are needed for the parts that depend on absolute timing and on the thresholds being strict:
- The exact cycle of the first increment after activation.
- A count sitting equal to a watermark without raising a flag.
- Grant and expiry colliding in one cycle.
- A zero interval.

// File: rtl/refresh_owed_tracker.sv
`timescale 1ns/1ps
module refresh_owed_tracker #(
  parameter int TMR_W = 14,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             init_done,
  input  logic [TMR_W-1:0] interval_ld,
  input  logic [CNT_W-1:0] lo_mark,
  input  logic [CNT_W-1:0] hi_mark,
  input  logic [CNT_W-1:0] hyst_lvl,
  input  logic             ref_grant,
  output logic             req_lo,
  output logic             req_hi,
  output logic [CNT_W-1:0] owed_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             active, tick, up, dn, hi_q, hi_d;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W:0]   tmr_nx;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign active = ref_en & init_done;
  assign tmr_nx = {1'b0, tmr_q} + (TMR_W+1)'(1);
  assign tick   = active && (tmr_nx >= {1'b0, interval_ld});
  assign up     = tick && !ref_grant && (cnt_q != CNT_MAX);
  assign dn     = active && ref_grant && !tick && (cnt_q != '0);

  always_comb begin
    if (!active)  cnt_d = '0;
    else if (up)  cnt_d = cnt_q + CNT_ONE;
    else if (dn)  cnt_d = cnt_q - CNT_ONE;
    else          cnt_d = cnt_q;
  end

  always_comb begin
    if (!active)               hi_d = 1'b0;
    else if (cnt_d > hi_mark)  hi_d = 1'b1;
    else if (cnt_d < hyst_lvl) hi_d = 1'b0;
    else                       hi_d = hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      if (!active || tick) tmr_q <= '0;
      else                 tmr_q <= tmr_nx[TMR_W-1:0];
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign req_lo   = active && (cnt_q > lo_mark);
  assign req_hi   = hi_q;
  assign owed_cnt = cnt_q;
endmodule

// File: rtl/refresh_owed_tracker_chk.sv
`timescale 1ns/1ps
module refresh_owed_tracker_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_en,
  input logic             init_done,
  input logic             ref_grant,
  input logic             tick,
  input logic [CNT_W-1:0] hi_mark,
  input logic [CNT_W-1:0] hyst_lvl,
  input logic             req_hi,
  input logic [CNT_W-1:0] owed_cnt
);
  logic on;
  assign on = ref_en && init_done;

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (owed_cnt == '0) && !req_hi);

  // R7
  grant_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && ref_grant && !tick && owed_cnt != '0) |=> owed_cnt == $past(owed_cnt) - 1'b1);

  // R3
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && tick && !ref_grant && owed_cnt != '1) |=> owed_cnt == $past(owed_cnt) + 1'b1);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && owed_cnt == '1) |=> owed_cnt != '0 || !$past(on));

  // R5
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_hi) |-> owed_cnt > $past(hi_mark));

  // R6
  hi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_hi) |-> (!$past(on) || owed_cnt < $past(hyst_lvl)));
endmodule

bind refresh_owed_tracker refresh_owed_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .init_done(init_done),
  .ref_grant(ref_grant), .tick(tick), .hi_mark(hi_mark), .hyst_lvl(hyst_lvl),
  .req_hi(req_hi), .owed_cnt(owed_cnt)
);

// File: tb/sim_refresh_owed_tracker.sv
`timescale 1ns/1ps
module sim_refresh_owed_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0, init_done = 1'b0, ref_grant = 1'b0;
  logic [13:0] interval_ld = 14'd4;
  logic [3:0]  lo_mark = 4'd2, hi_mark = 4'd5, hyst_lvl = 4'd3;
  logic        req_lo, req_hi;
  logic [3:0]  owed_cnt;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refresh_owed_tracker u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .init_done(init_done),
    .interval_ld(interval_ld), .lo_mark(lo_mark), .hi_mark(hi_mark),
    .hyst_lvl(hyst_lvl), .ref_grant(ref_grant),
    .req_lo(req_lo), .req_hi(req_hi), .owed_cnt(owed_cnt)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect3(string req, int c, int lo, int hi);
    chk(req, "owed_cnt", owed_cnt, c);
    chk(req, "req_lo", req_lo, lo);
    chk(req, "req_hi", req_hi, hi);
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1;
    expect3("R10", 0, 0, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    cycles(1);
    expect3("R10", 0, 0, 0);
  endtask

  task automatic t_disabled;
    ref_en = 1'b0; init_done = 1'b1;
    cycles(20);
    expect3("R1", 0, 0, 0);
  endtask

  task automatic t_init_gate;
    ref_en = 1'b1; init_done = 1'b0;
    cycles(20);
    expect3("R2", 0, 0, 0);
  endtask

  task automatic t_climb;
    init_done = 1'b1;
    cycles(3); expect3("R3", 0, 0, 0);
    cycles(1); expect3("R3", 1, 0, 0);
    cycles(4); expect3("R4", 2, 0, 0);
    cycles(4); expect3("R4", 3, 1, 0);
    cycles(8); expect3("R5", 5, 1, 0);
    cycles(4); expect3("R5", 6, 1, 1);
  endtask

  task automatic grant1(string req, int c, int lo, int hi);
    ref_grant = 1'b1;
    cycles(1);
    expect3(req, c, lo, hi);
  endtask

  task automatic t_drain;
    grant1("R7", 5, 1, 1);
    grant1("R6", 4, 1, 1);
    grant1("R6", 3, 1, 1);
    grant1("R7", 3, 1, 1);
    grant1("R6", 2, 0, 0);
    grant1("R7", 1, 0, 0);
    grant1("R7", 0, 0, 0);
    grant1("R7", 0, 0, 0);
    grant1("R8", 0, 0, 0);
    ref_grant = 1'b0;
  endtask

  task automatic t_saturate;
    cycles(80); expect3("R9", 15, 1, 1);
    cycles(8);  expect3("R9", 15, 1, 1);
    cycles(1);
    grant1("R9", 14, 1, 1);
    ref_grant = 1'b0;
  endtask

  task automatic t_disable_clear;
    ref_en = 1'b0;
    #1; chk("R1", "req_lo", req_lo, 0);
    cycles(1); expect3("R1", 0, 0, 0);
    cycles(5); expect3("R1", 0, 0, 0);
  endtask

  task automatic t_period7;
    interval_ld = 14'd7;
    ref_en = 1'b1;
    cycles(6); expect3("R3", 0, 0, 0);
    cycles(1); expect3("R3", 1, 0, 0);
    cycles(7); expect3("R3", 2, 0, 0);
  endtask

  task automatic t_zero;
    interval_ld = 14'd0;
    cycles(3); expect3("R3", 5, 1, 0);
    interval_ld = 14'd4;
    ref_en = 1'b0;
    cycles(1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_init_gate();
    t_climb();
    t_drain();
    t_saturate();
    t_disable_clear();
    t_period7();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule